// File: doc/BRIEF.md
# Programmable Test Picture Generator

This block produces a synthetic video raster for bring-up and test of a display pipeline, standing in for a sampled camera or front-end source. A free-running pixel counter and line counter walk a frame whose total line length and total line count are programmable. Inside that frame an active picture of programmable width and height is flagged with a data-enable, and the generator emits a line-start marker, a frame-start marker and the current pixel coordinates with every pixel.

Inside the active picture the colour follows a stepped ramp. Horizontally, two independent column intervals each trigger a colour change: the first adds an increment, the second subtracts a decrement. Vertically, one line interval adds a vertical increment. The horizontal ramp drives red, the vertical ramp drives green, and blue carries their sum. All colour arithmetic wraps modulo the component range, so large steps produce repeating bands rather than saturating. If a programmed total is not larger than the matching active size, the total is raised so that at least one blanking pixel per line and one blanking line per frame remain.

Top module: `pattern_gen_top`

## Requirements
- R1: The column coordinate counts 0 up to the effective line length minus one, then returns to 0 while the line coordinate advances by one; after the last line of the effective frame both coordinates return to 0.
- R2: The effective line length is the total line length when it exceeds the active width, otherwise active width plus one; the effective line count follows the same rule against the active height.
- R3: Data-enable is 1 exactly when the column is below the active width and the line is below the active height; outside that area red, green and blue are all 0.
- R4: Inside the active area, red equals (h_inc × floor(x / h_step_a) − h_dec × floor(x / h_step_b)) modulo 256, where a step length of 0 removes its term.
- R5: Inside the active area, green equals (v_inc × floor(y / v_step)) modulo 256, where a v_step of 0 keeps green at 0.
- R6: Inside the active area, blue equals (red + green) modulo 256.
- R7: Line-start is 1 exactly when the column is 0; frame-start is 1 exactly when both column and line are 0.
- R8: An active-low reset, taking effect without waiting for a clock edge, returns the generator to column 0, line 0 with both colour ramps at 0; the first clock edge after release moves to column 1.
- R9: Colour steps that pass the top of the 8-bit range wrap around instead of saturating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| act_w | input | CW | Active picture width in pixels |
| act_h | input | CW | Active picture height in lines |
| tot_w | input | CW | Total pixels per line including blanking |
| tot_h | input | CW | Total lines per frame including blanking |
| h_step_a | input | CW | Column interval for the increment step (0 = off) |
| h_step_b | input | CW | Column interval for the decrement step (0 = off) |
| h_inc | input | COLW | Amount added at each increment step |
| h_dec | input | COLW | Amount subtracted at each decrement step |
| v_step | input | CW | Line interval for the vertical step (0 = off) |
| v_inc | input | COLW | Amount added at each vertical step |
| pix_x | output | CW | Current column |
| pix_y | output | CW | Current line |
| de | output | 1 | Active picture flag |
| line_start | output | 1 | Column 0 marker |
| frame_start | output | 1 | Column 0, line 0 marker |
| red | output | COLW | Red component (horizontal ramp) |
| green | output | COLW | Green component (vertical ramp) |
| blue | output | COLW | Blue component (sum of ramps) |

## Verification
Every output is a decode of the registered column, line and ramp state, so the values belonging to frame position n appear after exactly n rising edges following reset release, and position 0 is visible during reset itself. The bench releases reset on a falling edge, samples immediately for position 0, and then samples once per falling edge, comparing against position n computed from the requirement formulas. The reset check is taken one time step after reset is asserted mid-frame, before any clock edge, since the reset acts at once.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
   localparam int unsigned PG_COORD_W  = 12;
   localparam int unsigned PG_COLOUR_W = 8;
endpackage

// File: rtl/pgen_axis_cnt.sv
module pgen_axis_cnt #(
   parameter int unsigned CW = pgen_pkg::PG_COORD_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [CW-1:0] act_len,
   input  logic [CW-1:0] tot_len,
   output logic [CW-1:0] pos,
   output logic          wrap
);
   if (CW < 2) begin : g_bad_cw
      $error("pgen_axis_cnt: CW must be at least 2");
   end

   logic [CW:0] limit;
   logic [CW:0] pos_nxt;

   // total is raised above the active size when it leaves no blanking
   assign limit   = ({1'b0, tot_len} > {1'b0, act_len}) ? {1'b0, tot_len}
                                                         : {1'b0, act_len} + 1'b1;
   assign pos_nxt = {1'b0, pos} + 1'b1;
   assign wrap    = tick && (pos_nxt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos <= '0;
      else if (tick) pos <= wrap ? '0 : pos_nxt[CW-1:0];
   end

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (pos == '0));                                          // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(pos));                                        // R1
   AST_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(limit) && ({1'b0, pos} < limit)) |=>
      (!$stable(limit) || ({1'b0, pos} < limit)));                   // R2
endmodule

// File: rtl/pgen_step_ramp.sv
module pgen_step_ramp #(
   parameter int unsigned CW    = pgen_pkg::PG_COORD_W,
   parameter int unsigned COLW  = pgen_pkg::PG_COLOUR_W,
   parameter int unsigned NSTEP = 1,
   parameter logic [NSTEP-1:0] SUB_MASK = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       advance,
   input  logic                       restart,
   input  logic [NSTEP-1:0][CW-1:0]   step_len,
   input  logic [NSTEP-1:0][COLW-1:0] delta,
   output logic [COLW-1:0]            level
);
   if (NSTEP < 1) begin : g_bad_nstep
      $error("pgen_step_ramp: NSTEP must be at least 1");
   end
   if (COLW < 1) begin : g_bad_colw
      $error("pgen_step_ramp: COLW must be at least 1");
   end

   logic [NSTEP-1:0][COLW-1:0] term;
   logic [COLW-1:0]            sum;

   for (genvar g = 0; g < NSTEP; g++) begin : g_step
      logic [CW-1:0] ph;
      logic [CW:0]   ph_nxt;
      logic          hit;

      assign ph_nxt = {1'b0, ph} + 1'b1;
      assign hit    = advance && (step_len[g] != '0) &&
                      (ph_nxt >= {1'b0, step_len[g]});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ph <= '0;
         else if (restart) ph <= '0;
         else if (advance) ph <= hit ? '0 : ph_nxt[CW-1:0];
      end

      if (SUB_MASK[g]) begin : g_sub
         assign term[g] = hit ? (~delta[g] + 1'b1) : '0;
      end else begin : g_add
         assign term[g] = hit ? delta[g] : '0;
      end
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < NSTEP; i++) sum = sum + term[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       level <= '0;
      else if (restart) level <= '0;
      else if (advance) level <= level + sum;
   end

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (level == '0));                                     // R4
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !restart) |=> $stable(level));                    // R5
endmodule

// File: rtl/pattern_gen_top.sv
module pattern_gen_top #(
   parameter int unsigned CW   = pgen_pkg::PG_COORD_W,
   parameter int unsigned COLW = pgen_pkg::PG_COLOUR_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   act_w,
   input  logic [CW-1:0]   act_h,
   input  logic [CW-1:0]   tot_w,
   input  logic [CW-1:0]   tot_h,
   input  logic [CW-1:0]   h_step_a,
   input  logic [CW-1:0]   h_step_b,
   input  logic [COLW-1:0] h_inc,
   input  logic [COLW-1:0] h_dec,
   input  logic [CW-1:0]   v_step,
   input  logic [COLW-1:0] v_inc,
   output logic [CW-1:0]   pix_x,
   output logic [CW-1:0]   pix_y,
   output logic            de,
   output logic            line_start,
   output logic            frame_start,
   output logic [COLW-1:0] red,
   output logic [COLW-1:0] green,
   output logic [COLW-1:0] blue
);
   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("pattern_gen_top: CW must lie in 2..16");
   end
   if (COLW < 1 || COLW > 16) begin : g_bad_colw
      $error("pattern_gen_top: COLW must lie in 1..16");
   end

   logic            h_wrap, v_wrap;
   logic [COLW-1:0] h_level, v_level;

   pgen_axis_cnt #(.CW(CW)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .tick(1'b1),
      .act_len(act_w), .tot_len(tot_w), .pos(pix_x), .wrap(h_wrap));

   pgen_axis_cnt #(.CW(CW)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .tick(h_wrap),
      .act_len(act_h), .tot_len(tot_h), .pos(pix_y), .wrap(v_wrap));

   pgen_step_ramp #(.CW(CW), .COLW(COLW), .NSTEP(2), .SUB_MASK(2'b10)) u_hramp (
      .clk(clk), .rst_n(rst_n), .advance(!h_wrap), .restart(h_wrap),
      .step_len({h_step_b, h_step_a}), .delta({h_dec, h_inc}), .level(h_level));

   pgen_step_ramp #(.CW(CW), .COLW(COLW), .NSTEP(1), .SUB_MASK(1'b0)) u_vramp (
      .clk(clk), .rst_n(rst_n), .advance(h_wrap && !v_wrap), .restart(v_wrap),
      .step_len(v_step), .delta(v_inc), .level(v_level));

   assign de          = (pix_x < act_w) && (pix_y < act_h);
   assign line_start  = (pix_x == '0);
   assign frame_start = line_start && (pix_y == '0);
   assign red         = de ? h_level : '0;
   assign green       = de ? v_level : '0;
   assign blue        = de ? (h_level + v_level) : '0;

   AST_FRAME_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> line_start);                                    // R7
   AST_LINE_START_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      h_wrap |=> line_start);                                         // R7
endmodule

// File: tb/pattern_gen_top_tb_top.sv
`timescale 1ns/100ps
module pattern_gen_top_tb_top;
   localparam int CW = 12, COLW = 8, NV = 4, NF = 10;
   // fields: act_w act_h tot_w tot_h h_step_a h_step_b h_inc h_dec v_step v_inc
   localparam int VEC [NV][NF] = '{
      '{6, 3, 9, 5, 2, 3, 10, 4, 1, 16},
      '{5, 2, 3, 2, 1, 0, 200, 0, 2, 100},
      '{4, 4, 4, 4, 0, 1, 0, 7, 0, 50},
      '{0, 2, 4, 3, 1, 1, 1, 1, 1, 1}
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n;
   logic [CW-1:0]   act_w, act_h, tot_w, tot_h, h_step_a, h_step_b, v_step;
   logic [COLW-1:0] h_inc, h_dec, v_inc;
   logic [CW-1:0]   pix_x, pix_y;
   logic            de, line_start, frame_start;
   logic [COLW-1:0] red, green, blue;

   int n_chk = 0;
   int n_bad = 0;

   pattern_gen_top #(.CW(CW), .COLW(COLW)) dut_i (
      .clk(clk), .rst_n(rst_n), .act_w(act_w), .act_h(act_h),
      .tot_w(tot_w), .tot_h(tot_h), .h_step_a(h_step_a), .h_step_b(h_step_b),
      .h_inc(h_inc), .h_dec(h_dec), .v_step(v_step), .v_inc(v_inc),
      .pix_x(pix_x), .pix_y(pix_y), .de(de), .line_start(line_start),
      .frame_start(frame_start), .red(red), .green(green), .blue(blue));

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic apply(int v);
      act_w = CW'(VEC[v][0]); act_h = CW'(VEC[v][1]);
      tot_w = CW'(VEC[v][2]); tot_h = CW'(VEC[v][3]);
      h_step_a = CW'(VEC[v][4]); h_step_b = CW'(VEC[v][5]);
      h_inc = COLW'(VEC[v][6]); h_dec = COLW'(VEC[v][7]);
      v_step = CW'(VEC[v][8]); v_inc = COLW'(VEC[v][9]);
   endtask

   function automatic int eff(int act, int tot);
      return (tot > act) ? tot : act + 1;
   endfunction

   // samples position 0 at the call, then one position per falling edge
   task automatic scan(int v, int samples, string ctag, string rtag);
      int w = eff(VEC[v][0], VEC[v][2]);
      int h = eff(VEC[v][1], VEC[v][3]);
      for (int n = 0; n < samples; n++) begin
         int x = n % w;
         int y = (n / w) % h;
         int e = (x < VEC[v][0] && y < VEC[v][1]) ? 1 : 0;
         int r = ((VEC[v][4] != 0 ? VEC[v][6] * (x / VEC[v][4]) : 0) -
                  (VEC[v][5] != 0 ? VEC[v][7] * (x / VEC[v][5]) : 0)) & 255;
         int g = (VEC[v][8] != 0 ? VEC[v][9] * (y / VEC[v][8]) : 0) & 255;
         int b = (r + g) & 255;
         chk({ctag, " column"}, int'(pix_x), x);
         chk({ctag, " line"}, int'(pix_y), y);
         chk("R3 de", int'(de), e);
         chk("R7 line_start", int'(line_start), (x == 0) ? 1 : 0);
         chk("R7 frame_start", int'(frame_start), (x == 0 && y == 0) ? 1 : 0);
         chk({rtag, " red"}, int'(red), e ? r : 0);
         chk("R5 green", int'(green), e ? g : 0);
         chk("R6 blue", int'(blue), e ? b : 0);
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      apply(0);
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 reset column", int'(pix_x), 0);
      chk("R8 reset line", int'(pix_y), 0);
      chk("R8 reset frame_start", int'(frame_start), 1);
      chk("R8 reset red", int'(red), 0);

      // vector walk: R1 R2 R4 R9 coverage by vector
      for (int v = 0; v < NV; v++) begin
         int w;
         int h;
         rst_n = 1'b0;
         apply(v);
         @(negedge clk);
         rst_n = 1'b1;
         w = eff(VEC[v][0], VEC[v][2]);
         h = eff(VEC[v][1], VEC[v][3]);
         scan(v, w * h + w + 2,
              (v == 1 || v == 2) ? "R2" : "R1",
              (v == 1) ? "R9" : "R4");
      end

      // directed: reset asserted mid-frame takes effect at once (R8)
      rst_n = 1'b0;
      apply(0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (13) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R8 mid-frame column", int'(pix_x), 0);
      chk("R8 mid-frame line", int'(pix_y), 0);
      chk("R8 mid-frame line_start", int'(line_start), 1);
      chk("R8 mid-frame red", int'(red), 0);
      @(negedge clk);
      rst_n = 1'b1;
      scan(0, 12, "R8", "R4");

      summary();
      $finish;
   end
endmodule